// File: doc/BRIEF.md
# Iterative Fixed-Point Exponential Unit

This block computes e raised to an unsigned fractional argument in [0,1). The argument is a 16-bit pure fraction. The block sums Taylor terms, one term in each clock cycle. A rising edge on `start` captures the argument and seeds the running sum with 1 + x. Each following cycle forms the next term from the previous term, the captured argument and a stored reciprocal constant, then adds that term into an 18-bit sum.

The sum uses a 2.16 fixed-point format. Both multiplies in a cycle keep only the upper half of their double-width product. The host raises `start` for at least one cycle and waits for `busy` to fall. From then on, `resInt` and `resFrac` hold the answer until the next computation begins.

Top module: `exp_taylor_unit`

## Requirements
- R1: While `rst` is high, and after it is released, `busy` is 0 and the 18-bit result `{resInt,resFrac}` is 0 until a computation starts.
- R2: A computation starts on a rising clock edge at which `start` is 1, `start` was 0 at the previous edge, and the unit is idle. `busy` reads 1 directly after that edge.
- R3: `busy` stays high for exactly 15 consecutive cycles, one for each iteration index i = 2 through 16. It then falls.
- R4: On the start edge the result loads 1.0 + x, which is `{2'b01, x}`, and the term register loads x.
- R5: Each iteration computes the new term as T' = hi16(hi16(T·x) · r_i). Here hi16 keeps bits [31:16] of a 32-bit product. T' is added to the result, so the result never decreases while busy.
- R6: The reciprocal constant r_i is floor(65536 / i) for i ≥ 2, and 16'hFFFF for i = 1. Index 16 sits at 4-bit address 0.
- R7: The result is a 2.16 value: `resInt` carries bits [17:16] and `resFrac` carries bits [15:0]. For x = 16'hFFFF, `resInt` is 2.
- R8: A `start` pulse that arrives while busy has no effect. x is sampled only on the start edge, so changing x during a computation does not change the result.
- R9: After `busy` falls the result stays constant until the next start. Holding `start` high across completion does not restart the unit. A new computation needs `start` low for one cycle, then a new rising edge.
- R10: For x = 16'h998D the result is within 40 LSB of 2'b01.16'hD259. For x = 16'h5212 it is within 40 LSB of 2'b01.16'h60BA.
- R11: For x = 0 the result is exactly 1.0 (18'h10000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request; acts on its rising edge |
| xIn | input | 16 | Unsigned fractional argument |
| busy | output | 1 | High while iterations run |
| resInt | output | 2 | Integer bits of the result |
| resFrac | output | 16 | Fractional bits of the result |

## Verification
The result is visible on every cycle, and it grows by exactly one term on each busy cycle. A wrong reciprocal entry, a dropped truncation or a stale argument therefore shows up as a differing sum on the very cycle of the faulty iteration, not only at the end. A counter or controller fault shows up as a `busy` run that is not 15 cycles long, or as an idle result that still moves. Comparing against a behavioural model on every clock catches either kind within one cycle.

// File: rtl/exp_pkg.sv
package exp_pkg;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned INT_W  = 2;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [1:0] {
    ST_WAITING = 2'd0,
    ST_BUSY    = 2'd1,
    ST_DONE    = 2'd2
  } exp_state_t;

  typedef struct packed {
    logic load;
    logic step;
  } exp_strobe_t;
endpackage

// File: rtl/exp_recip_rom.sv
module exp_recip_rom #(
  parameter int unsigned FRAC_W = exp_pkg::FRAC_W,
  parameter int unsigned CNT_W  = exp_pkg::CNT_W
) (
  input  logic [CNT_W-1:0]  addr,
  output logic [FRAC_W-1:0] recip
);
  localparam int unsigned DEPTH = 1 << CNT_W;

  logic [FRAC_W-1:0] romArr [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    // address 0 stands for index DEPTH after counter wrap
    localparam longint unsigned IDX = (a == 0) ? longint'(DEPTH) : longint'(a);
    localparam longint unsigned ONE = 64'd1 << FRAC_W;
    localparam longint unsigned VAL = (IDX == 1) ? (ONE - 64'd1) : (ONE / IDX);
    assign romArr[a] = FRAC_W'(VAL);
  end

  assign recip = romArr[addr];
endmodule

// File: rtl/exp_mul_trunc.sv
module exp_mul_trunc #(
  parameter int unsigned W = exp_pkg::FRAC_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] prodHi
);
  logic [2*W-1:0] prodFull;

  always_comb begin
    prodFull = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};
    prodHi   = prodFull[2*W-1:W];
  end
endmodule

// File: rtl/exp_ctrl.sv
module exp_ctrl
  import exp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        lastTerm,
  output exp_strobe_t stb,
  output logic        busy
);
  exp_state_t stateQ, stateD;
  logic       startPrev;
  logic       startRise;

  assign startRise = start & ~startPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= ST_WAITING;
      startPrev <= 1'b0;
    end else begin
      stateQ    <= stateD;
      startPrev <= start;
    end
  end

  always_comb begin
    stateD   = stateQ;
    stb.load = 1'b0;
    stb.step = 1'b0;
    unique case (stateQ)
      ST_WAITING: begin
        if (startRise) begin
          stb.load = 1'b1;
          stateD   = ST_BUSY;
        end
      end
      ST_BUSY: begin
        stb.step = 1'b1;
        if (lastTerm) stateD = ST_DONE;
      end
      ST_DONE: begin
        if (!start) stateD = ST_WAITING;
      end
      default: stateD = ST_WAITING;
    endcase
  end

  assign busy = (stateQ == ST_BUSY);
endmodule

// File: rtl/exp_datapath.sv
module exp_datapath
  import exp_pkg::*;
#(
  parameter int unsigned FRAC_W = exp_pkg::FRAC_W,
  parameter int unsigned INT_W  = exp_pkg::INT_W,
  parameter int unsigned CNT_W  = exp_pkg::CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  exp_strobe_t             stb,
  input  logic [FRAC_W-1:0]       xIn,
  output logic                    lastTerm,
  output logic [FRAC_W+INT_W-1:0] sum
);
  localparam int unsigned ACC_W = FRAC_W + INT_W;

  logic [FRAC_W-1:0] xReg;
  logic [FRAC_W-1:0] termQ;
  logic [ACC_W-1:0]  accQ;
  logic [CNT_W-1:0]  idxQ;
  logic [FRAC_W-1:0] recipVal;
  logic [FRAC_W-1:0] termTimesX;
  logic [FRAC_W-1:0] termNext;

  exp_recip_rom #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_rom (
    .addr  (idxQ),
    .recip (recipVal)
  );

  exp_mul_trunc #(.W(FRAC_W)) u_mulX (
    .opA    (termQ),
    .opB    (xReg),
    .prodHi (termTimesX)
  );

  exp_mul_trunc #(.W(FRAC_W)) u_mulR (
    .opA    (termTimesX),
    .opB    (recipVal),
    .prodHi (termNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg  <= '0;
      termQ <= '0;
      accQ  <= '0;
      idxQ  <= '0;
    end else if (stb.load) begin
      xReg  <= xIn;
      termQ <= xIn;
      accQ  <= {INT_W'(1), xIn};
      idxQ  <= CNT_W'(2);
    end else if (stb.step) begin
      termQ <= termNext;
      accQ  <= accQ + {{INT_W{1'b0}}, termNext};
      idxQ  <= idxQ + CNT_W'(1);
    end
  end

  assign lastTerm = (idxQ == '0);
  assign sum      = accQ;
endmodule

// File: rtl/exp_taylor_unit.sv
module exp_taylor_unit
  import exp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAC_W-1:0]  xIn,
  output logic               busy,
  output logic [INT_W-1:0]   resInt,
  output logic [FRAC_W-1:0]  resFrac
);
  exp_strobe_t             stb;
  logic                    lastTerm;
  logic [FRAC_W+INT_W-1:0] sum;

  exp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lastTerm (lastTerm),
    .stb      (stb),
    .busy     (busy)
  );

  exp_datapath #(.FRAC_W(FRAC_W), .INT_W(INT_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .xIn      (xIn),
    .lastTerm (lastTerm),
    .sum      (sum)
  );

  assign resInt  = sum[FRAC_W+INT_W-1:FRAC_W];
  assign resFrac = sum[FRAC_W-1:0];
endmodule

// File: rtl/exp_taylor_checker.sv
module exp_taylor_checker
  import exp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [FRAC_W-1:0] xIn,
  input logic              busy,
  input logic [INT_W-1:0]  resInt,
  input logic [FRAC_W-1:0] resFrac
);
  localparam int unsigned ITERS = (1 << CNT_W) - 1;

  logic [FRAC_W+INT_W-1:0] res;
  logic [CNT_W:0]          runLen;

  assign res = {resInt, resFrac};

  always_ff @(posedge clk) begin
    if (rst || !busy) runLen <= '0;
    else              runLen <= runLen + 1'b1;
  end

  // R3: busy run ends after exactly ITERS cycles
  a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (runLen == (CNT_W+1)'(ITERS)));

  // R3: busy run never exceeds ITERS
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (runLen < (CNT_W+1)'(ITERS)));

  // R4: start seeds the sum with 1.0 + x
  a_r4_seed_value: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (res == {INT_W'(1), $past(xIn)}));

  // R5: the sum never decreases while iterating
  a_r5_sum_monotone: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (res >= $past(res)));

  // R7: e^x stays below 3 for x in [0,1)
  a_r7_int_below_three: assert property (@(posedge clk) disable iff (rst)
    resInt != 2'b11);

  // R9: the result holds while idle
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(res));
endmodule

bind exp_taylor_unit exp_taylor_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .xIn     (xIn),
  .busy    (busy),
  .resInt  (resInt),
  .resFrac (resFrac)
);

// File: tb/exp_taylor_unit_bench.sv
module exp_taylor_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] xIn = '0;
  logic        busy;
  logic [1:0]  resInt;
  logic [15:0] resFrac;

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 0;
  bit seenEdge = 0;
  int cycleCnt = 0;

  // behavioural reference state
  int              mState = 0;  // 0 idle, 1 iterating, 2 finished
  bit              mPrev = 0;
  longint unsigned mX = 0, mTerm = 0, mAcc = 0;
  int              mI = 0;

  exp_taylor_unit u_exp_taylor_unit (
    .clk(clk), .rst(rst), .start(start), .xIn(xIn),
    .busy(busy), .resInt(resInt), .resFrac(resFrac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint unsigned recipOf(int i);
    return (i == 1) ? 64'd65535 : (64'd65536 / longint'(i));
  endfunction

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycleCnt);
    end
  endtask

  always @(posedge clk) begin
    seenEdge <= 1'b1;
    cycleCnt <= cycleCnt + 1;
    if (rst) begin
      mState = 0; mPrev = 0; mX = 0; mTerm = 0; mAcc = 0; mI = 0;
    end else begin
      case (mState)
        0: if (start && !mPrev) begin
             mX = xIn; mTerm = xIn; mAcc = 64'd65536 + xIn; mI = 2; mState = 1;
           end
        1: begin
             longint unsigned t;
             t = (mTerm * mX) >> 16;
             t = (t * recipOf(mI)) >> 16;
             mTerm = t;
             mAcc = mAcc + t;
             if (mI == 16) mState = 2;
             mI++;
           end
        default: if (!start) mState = 0;
      endcase
      mPrev = start;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (seenEdge && !summaryDone) begin
      string tagB, tagR;
      tagB = rst ? "R1" : "R3";
      tagR = rst ? "R1" : ((mState == 1) ? "R5" : "R9");
      check(busy == (mState == 1), tagB, busy, (mState == 1));
      check({resInt, resFrac} == mAcc[17:0], tagR, {resInt, resFrac}, mAcc[17:0]);
    end
  end

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycleCnt > 5000 && !summaryDone) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycleCnt);
      finishRun();
    end
  end

  // start a computation; returns busy length and final result
  task automatic runOne(input logic [15:0] xv, input bit midPulse, input bit wiggleX,
                        output int len, output logic [17:0] res);
    @(negedge clk);
    xIn = xv; start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R2", busy, 1);
    check({resInt, resFrac} == {2'b01, xv}, "R4", {resInt, resFrac}, {2'b01, xv});
    start = 1'b0;
    len = 0;
    while (busy) begin
      len++;
      if (wiggleX) xIn = ~xIn;
      if (midPulse && len == 5) start = 1'b1;
      if (midPulse && len == 6) start = 1'b0;
      @(negedge clk);
    end
    res = {resInt, resFrac};
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic longint unsigned absDiff(longint unsigned a, longint unsigned b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    int len;
    logic [17:0] res, ref8000;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && {resInt, resFrac} == 18'h0, "R1", {busy, resInt, resFrac}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check({resInt, resFrac} == 18'h0, "R1", {resInt, resFrac}, 0);

    runOne(16'h998D, 0, 0, len, res);
    check(len == 15, "R3", len, 15);
    check(absDiff(res, 18'h1D259) <= 40, "R10", res, 18'h1D259);

    runOne(16'h5212, 0, 0, len, res);
    check(absDiff(res, 18'h160BA) <= 40, "R10", res, 18'h160BA);

    runOne(16'h0000, 0, 0, len, res);
    check(res == 18'h10000, "R11", res, 18'h10000);
    check(len == 15, "R3", len, 15);

    runOne(16'hFFFF, 0, 0, len, res);
    check(resInt == 2'd2, "R7", resInt, 2);
    check(res == mAcc[17:0], "R6", res, mAcc[17:0]);

    runOne(16'h8000, 0, 0, len, ref8000);
    runOne(16'h8000, 1, 1, len, res);
    check(res == ref8000, "R8", res, ref8000);
    check(len == 15, "R8", len, 15);

    // R9: start held high across completion must not restart
    @(negedge clk);
    xIn = 16'h4000; start = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    res = {resInt, resFrac};
    repeat (6) begin
      @(negedge clk);
      check(busy == 1'b0, "R9", busy, 0);
    end
    check({resInt, resFrac} == res, "R9", {resInt, resFrac}, res);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R9", busy, 1);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule